// File: doc/BRIEF.md
# Elastic-FIFO Rate Tracking Controller

This block holds a transmit video clock at the same average rate as an incoming video stream. Between the receive and transmit clock domains there is an elastic FIFO. The controller reads that FIFO's fill count and its full and empty flags. It steers the fractional divider word of a PLL so that the FIFO stays near half full.

After reset, the controller holds the FIFO in reset for a fixed number of cycles. It then waits for the fill count to reach exactly half the depth. At that point it enables the transmit timing generator. From then on, it compares the fill against the half-full set-point once per video frame. A fill above the set-point raises the fractional word and a fill below it lowers the word. The size of each correction is either a fixed step or a step proportional to the error. The word is clamped between two limits supplied on input ports.

The controller keeps a last known-good value of the word. If the FIFO runs full or empty while tracking, the controller drops the timing enable, resets the FIFO, reloads the known-good word and starts acquisition again. Status outputs report the current phase and a saturating count of restarts.

Top module: `fill_rate_tracker`

## Requirements
- R1: While reset is asserted, the outputs are: fifo_rst high, tmg_en low, state code 0, frac_word equal to FRAC_INIT, frac_upd low and restarts 0. After reset or after any restart, fifo_rst stays high for exactly RST_CYCLES cycles.
- R2: After fifo_rst falls, tmg_en stays low until a cycle in which the fill equals DEPTH/2. tmg_en is high from the next cycle on.
- R3: While tracking, the fill is evaluated once every FRAME_LEN cycles. The first evaluation takes effect on frac_word at the FRAME_LEN-th clock edge after tmg_en rises. frac_word never changes between evaluations.
- R4: A sampled fill above DEPTH/2 raises frac_word by the step.
- R5: A sampled fill below DEPTH/2 lowers frac_word by the step.
- R6: While tracking, fifo_full or fifo_empty causes fifo_rst to be high and tmg_en low in the next cycle, and acquisition starts again. During acquisition, fifo_full also restarts the sequence, but fifo_empty is ignored.
- R7: On every restart, frac_word is reloaded with the last known-good value. That value starts at FRAC_INIT.
- R8: With STEP_MODE 0, the step is STEP_FIXED. With STEP_MODE 1, the step is |fill - DEPTH/2| shifted left by STEP_SHIFT.
- R9: After an adjustment, frac_word is clamped to the range cfg_frac_min to cfg_frac_max.
- R10: frac_upd is high for exactly one cycle, in the cycle where frac_word takes a new value. It stays low when an evaluation or a reload leaves the word unchanged.
- R11: At an evaluation where |fill - DEPTH/2| <= cfg_tol (including zero error), the word as it stood before that evaluation becomes the known-good value.
- R12: state_o reports 0 during the FIFO reset phase, 1 during acquisition and 2 while tracking. restarts counts restarts and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill | input | FILL_W | Current FIFO fill count |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| cfg_frac_min | input | FRAC_W | Lower clamp for the fractional word |
| cfg_frac_max | input | FRAC_W | Upper clamp for the fractional word |
| cfg_tol | input | FILL_W | Error band for known-good capture |
| fifo_rst | output | 1 | Reset to the elastic FIFO |
| tmg_en | output | 1 | Enable for the TX video timing generator |
| frac_word | output | FRAC_W | Fractional divider word to the PLL |
| frac_upd | output | 1 | One-cycle strobe on each change of frac_word |
| state_o | output | 2 | Phase code: 0 reset, 1 acquire, 2 track |
| restarts | output | CNT_W | Saturating restart count |

## Verification
The bench builds two instances with a 16-entry FIFO (set-point 8), a 20-cycle frame, a 4-cycle FIFO reset phase, a 16-bit word starting at 1000, and a small restart counter. With these values, whole frames and repeated restarts take only a few hundred cycles. The first instance uses fixed steps of 4 with a tolerance of 1. The small tolerance separates in-band errors from out-of-band errors, and a lowered upper limit makes the clamp bite within two frames. The second instance uses the proportional step with a shift of 1. With a raised lower limit, a single large negative error drives the word into its floor.

// File: rtl/frt_pkg.sv
package frt_pkg;
   typedef enum logic [1:0] {
      ST_RESET = 2'd0,
      ST_ACQ   = 2'd1,
      ST_TRACK = 2'd2
   } frt_state_e;
endpackage

// File: rtl/frt_seq.sv
module frt_seq
   import frt_pkg::*;
#(
   parameter int FILL_W     = 10,
   parameter int SETPT      = 256,
   parameter int RST_CYCLES = 16,
   parameter int CNT_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] fill_i,
   input  logic              full_i,
   input  logic              empty_i,
   output logic              fifo_rst_o,
   output logic              run_o,
   output logic              restart_o,
   output logic [1:0]        state_o,
   output logic [CNT_W-1:0]  restarts_o
);
   localparam int RC_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_CYCLES - 1);

   frt_state_e       state_q;
   logic [RC_W-1:0]  rcnt_q;
   logic [CNT_W-1:0] rsts_q;

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end

   always_comb begin
      restart_o = ((state_q == ST_TRACK) && (full_i || empty_i)) ||
                  ((state_q == ST_ACQ) && full_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RESET;
         rcnt_q  <= '0;
         rsts_q  <= '0;
      end else if (restart_o) begin
         state_q <= ST_RESET;
         rcnt_q  <= '0;
         if (rsts_q != '1) rsts_q <= rsts_q + 1'b1;
      end else begin
         case (state_q)
            ST_RESET: begin
               if (rcnt_q == RC_LAST) begin
                  state_q <= ST_ACQ;
                  rcnt_q  <= '0;
               end else begin
                  rcnt_q <= rcnt_q + 1'b1;
               end
            end
            ST_ACQ:   if (fill_i == FILL_W'(SETPT)) state_q <= ST_TRACK;
            ST_TRACK: state_q <= ST_TRACK;
            default:  state_q <= ST_RESET;
         endcase
      end
   end

   assign fifo_rst_o = (state_q == ST_RESET);
   assign run_o      = (state_q == ST_TRACK);
   assign state_o    = state_q;
   assign restarts_o = rsts_q;

   // R2: tracking is entered only from a set-point hit during acquisition
   a_r2_enter_at_setpt: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TRACK && $past(state_q) == ST_ACQ) |-> $past(fill_i) == FILL_W'(SETPT));

   // R6: a full or empty flag while tracking forces the reset phase
   a_r6_flag_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TRACK && (full_i || empty_i)) |=> state_q == ST_RESET);
endmodule

// File: rtl/frt_frame_timer.sv
module frt_frame_timer #(
   parameter int FRAME_LEN = 2475000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int TW = $clog2(FRAME_LEN);
   localparam logic [TW-1:0] T_LAST = TW'(FRAME_LEN - 1);

   logic [TW-1:0] cnt_q;

   if (FRAME_LEN < 2) begin : g_bad_len
      $error("FRAME_LEN must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i)   cnt_q <= '0;
      else if (cnt_q == T_LAST) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = run_i && (cnt_q == T_LAST);

   // R3: a frame tick needs tracking to have been running the cycle before
   a_r3_tick_in_track: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(run_i));
endmodule

// File: rtl/frt_step_calc.sv
module frt_step_calc #(
   parameter int FILL_W     = 10,
   parameter int FRAC_W     = 24,
   parameter int SETPT      = 256,
   parameter int STEP_MODE  = 0,
   parameter int STEP_FIXED = 1,
   parameter int STEP_SHIFT = 0
) (
   input  logic [FILL_W-1:0] fill_i,
   input  logic [FILL_W-1:0] tol_i,
   output logic              up_o,
   output logic              dn_o,
   output logic              band_o,
   output logic [FRAC_W-1:0] step_o
);
   localparam int EW = FILL_W + 1;

   logic signed [EW-1:0] err;
   logic [FILL_W-1:0]    mag;

   if (FRAC_W <= FILL_W + STEP_SHIFT) begin : g_bad_w
      $error("FRAC_W too narrow for scaled step");
   end
   if (STEP_MODE != 0 && STEP_MODE != 1) begin : g_bad_mode
      $error("STEP_MODE must be 0 or 1");
   end

   always_comb begin
      err    = $signed({1'b0, fill_i}) - $signed(EW'(SETPT));
      mag    = err[EW-1] ? FILL_W'(-err) : FILL_W'(err);
      up_o   = !err[EW-1] && (err != '0);
      dn_o   = err[EW-1];
      band_o = (mag <= tol_i);
   end

   if (STEP_MODE == 0) begin : g_fixed
      assign step_o = FRAC_W'(STEP_FIXED);
   end else begin : g_scaled
      assign step_o = {{(FRAC_W - FILL_W){1'b0}}, mag} << STEP_SHIFT;
   end
endmodule

// File: rtl/fill_rate_tracker.sv
module fill_rate_tracker #(
   parameter int DEPTH      = 512,
   parameter int FILL_W     = 10,
   parameter int FRAC_W     = 24,
   parameter int FRAME_LEN  = 2475000,
   parameter int RST_CYCLES = 16,
   parameter int STEP_MODE  = 0,
   parameter int STEP_FIXED = 1,
   parameter int STEP_SHIFT = 0,
   parameter int FRAC_INIT  = 8388608,
   parameter int CNT_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] fill,
   input  logic              fifo_full,
   input  logic              fifo_empty,
   input  logic [FRAC_W-1:0] cfg_frac_min,
   input  logic [FRAC_W-1:0] cfg_frac_max,
   input  logic [FILL_W-1:0] cfg_tol,
   output logic              fifo_rst,
   output logic              tmg_en,
   output logic [FRAC_W-1:0] frac_word,
   output logic              frac_upd,
   output logic [1:0]        state_o,
   output logic [CNT_W-1:0]  restarts
);
   localparam int SETPT = DEPTH / 2;
   localparam int XW    = FRAC_W + 2;

   if (DEPTH < 4 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("DEPTH must be even and at least 4");
   end
   if (FILL_W < $clog2(DEPTH + 1)) begin : g_bad_fill
      $error("FILL_W cannot hold DEPTH");
   end

   logic              restart, run, tick, up, dn, band;
   logic [FRAC_W-1:0] step;
   logic [FRAC_W-1:0] frac_q, good_q, frac_d, good_d;
   logic              upd_q;
   logic signed [XW-1:0] cand;

   frt_seq #(
      .FILL_W(FILL_W), .SETPT(SETPT), .RST_CYCLES(RST_CYCLES), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .fill_i(fill), .full_i(fifo_full),
      .empty_i(fifo_empty), .fifo_rst_o(fifo_rst), .run_o(run),
      .restart_o(restart), .state_o(state_o), .restarts_o(restarts)
   );

   frt_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(run), .tick_o(tick)
   );

   frt_step_calc #(
      .FILL_W(FILL_W), .FRAC_W(FRAC_W), .SETPT(SETPT), .STEP_MODE(STEP_MODE),
      .STEP_FIXED(STEP_FIXED), .STEP_SHIFT(STEP_SHIFT)
   ) u_step (
      .fill_i(fill), .tol_i(cfg_tol), .up_o(up), .dn_o(dn),
      .band_o(band), .step_o(step)
   );

   always_comb begin
      cand = dn ? ($signed({2'b00, frac_q}) - $signed({2'b00, step}))
                : ($signed({2'b00, frac_q}) + $signed({2'b00, step}));
      if (cand < $signed({2'b00, cfg_frac_min}))
         cand = $signed({2'b00, cfg_frac_min});
      else if (cand > $signed({2'b00, cfg_frac_max}))
         cand = $signed({2'b00, cfg_frac_max});
   end

   always_comb begin
      frac_d = frac_q;
      good_d = good_q;
      if (restart) begin
         frac_d = good_q;
      end else if (tick) begin
         if (band) good_d = frac_q;
         if (up || dn) frac_d = FRAC_W'(cand);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frac_q <= FRAC_W'(FRAC_INIT);
         good_q <= FRAC_W'(FRAC_INIT);
         upd_q  <= 1'b0;
      end else begin
         frac_q <= frac_d;
         good_q <= good_d;
         upd_q  <= (frac_d != frac_q);
      end
   end

   assign tmg_en    = run;
   assign frac_word = frac_q;
   assign frac_upd  = upd_q;

   // R10: the word only moves together with its strobe
   a_r10_stable_no_upd: assert property (@(posedge clk) disable iff (!rst_n)
      !frac_upd |-> $stable(frac_word));

   // R9: an adjusted word lies inside the configured limits
   a_r9_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      (frac_upd && $past(tick) && !$past(restart)) |->
         (frac_word >= cfg_frac_min && frac_word <= cfg_frac_max));

   // R7: a restart leaves the known-good value on the word
   a_r7_reload_good: assert property (@(posedge clk) disable iff (!rst_n)
      $past(restart) |-> frac_word == $past(good_q));

   // R3: no word change while tracking outside a frame tick
   a_r3_no_midframe: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && !$past(tick) && !$past(restart)) |-> !frac_upd);
endmodule

// File: tb/tb_fill_rate_tracker.sv
module tb_fill_rate_tracker;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int tests = 0;
   int fails = 0;

   logic [4:0]  fill_a = '0, fill_b = '0, tol_a = 5'd1, tol_b = 5'd0;
   logic        full_a = 1'b0, empty_a = 1'b1, full_b = 1'b0, empty_b = 1'b1;
   logic [15:0] min_a = 16'd900, max_a = 16'd2000, min_b = 16'd1000, max_b = 16'd2000;
   logic        frst_a, en_a, upd_a, frst_b, en_b, upd_b;
   logic [15:0] frac_a, frac_b;
   logic [1:0]  st_a, st_b;
   logic [3:0]  rc_a, rc_b;

   fill_rate_tracker #(
      .DEPTH(16), .FILL_W(5), .FRAC_W(16), .FRAME_LEN(20), .RST_CYCLES(4),
      .STEP_MODE(0), .STEP_FIXED(4), .STEP_SHIFT(0), .FRAC_INIT(1000), .CNT_W(4)
   ) dut (
      .clk(clk), .rst_n(rst_n), .fill(fill_a), .fifo_full(full_a),
      .fifo_empty(empty_a), .cfg_frac_min(min_a), .cfg_frac_max(max_a),
      .cfg_tol(tol_a), .fifo_rst(frst_a), .tmg_en(en_a), .frac_word(frac_a),
      .frac_upd(upd_a), .state_o(st_a), .restarts(rc_a)
   );

   fill_rate_tracker #(
      .DEPTH(16), .FILL_W(5), .FRAC_W(16), .FRAME_LEN(20), .RST_CYCLES(4),
      .STEP_MODE(1), .STEP_FIXED(4), .STEP_SHIFT(1), .FRAC_INIT(1000), .CNT_W(4)
   ) dut_sc (
      .clk(clk), .rst_n(rst_n), .fill(fill_b), .fifo_full(full_b),
      .fifo_empty(empty_b), .cfg_frac_min(min_b), .cfg_frac_max(max_b),
      .cfg_tol(tol_b), .fifo_rst(frst_b), .tmg_en(en_b), .frac_word(frac_b),
      .frac_upd(upd_b), .state_o(st_b), .restarts(rc_b)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset_state();
      chk("R1", "fifo_rst in reset", frst_a, 1);
      chk("R1", "tmg_en in reset", en_a, 0);
      chk("R1", "frac_word init", frac_a, 1000);
      chk("R1", "frac_upd in reset", upd_a, 0);
      chk("R12", "state code reset", st_a, 0);
      chk("R12", "restarts init", rc_a, 0);
   endtask

   // enters acquisition from the reset phase and locks on the set-point
   task automatic acquire_a();
      int n = 0;
      full_a = 1'b0; empty_a = 1'b1; fill_a = 5'd0;
      while (frst_a && n < 50) begin n++; cyc(); end
      chk("R1", "fifo_rst length", n, 4);
      repeat (3) cyc();
      chk("R6", "empty ignored in acquire (rst)", frst_a, 0);
      chk("R12", "state code acquire", st_a, 1);
      fill_a = 5'd7; cyc();
      chk("R2", "no enable below set-point", en_a, 0);
      fill_a = 5'd8; empty_a = 1'b0; cyc();
      chk("R2", "enable at set-point", en_a, 1);
      chk("R12", "state code track", st_a, 2);
   endtask

   task automatic frame_a(input logic [4:0] f, input int exp_w, input int exp_u, input string req);
      int bad = 0;
      fill_a = f;
      for (int i = 0; i < 19; i++) begin cyc(); if (upd_a) bad++; end
      chk("R3", "no mid-frame update", bad, 0);
      cyc();
      chk(req, "frame word", frac_a, exp_w);
      chk("R10", "frame strobe", upd_a, exp_u);
   endtask

   task automatic t_track_a();
      acquire_a();
      frame_a(5'd10, 1004, 1, "R4");
      frame_a(5'd9, 1008, 1, "R11");
      frame_a(5'd12, 1012, 1, "R4");
      max_a = 16'd1014;
      frame_a(5'd12, 1014, 1, "R9");
      frame_a(5'd12, 1014, 0, "R9");
      frame_a(5'd5, 1010, 1, "R5");
      full_a = 1'b1; cyc();
      chk("R6", "full restarts: fifo_rst", frst_a, 1);
      chk("R6", "full restarts: tmg_en", en_a, 0);
      chk("R11", "reload in-band good", frac_a, 1004);
      chk("R7", "reload strobe", upd_a, 1);
      chk("R12", "restart count 1", rc_a, 1);
   endtask

   task automatic t_reacquire_a();
      acquire_a();
      frame_a(5'd10, 1008, 1, "R4");
      frame_a(5'd8, 1008, 0, "R10");
      frame_a(5'd5, 1004, 1, "R5");
      empty_a = 1'b1; cyc();
      chk("R6", "empty restarts", frst_a, 1);
      chk("R7", "reload zero-error good", frac_a, 1008);
      chk("R12", "restart count 2", rc_a, 2);
      chk("R12", "state code after restart", st_a, 0);
   endtask

   task automatic acquire_b();
      int n = 0;
      full_b = 1'b0; empty_b = 1'b1; fill_b = 5'd0;
      while (frst_b && n < 50) begin n++; cyc(); end
      fill_b = 5'd8; empty_b = 1'b0; cyc();
      chk("R2", "scaled enable", en_b, 1);
   endtask

   task automatic frame_b(input logic [4:0] f, input int exp_w, input string req);
      fill_b = f;
      repeat (20) cyc();
      chk(req, "scaled frame word", frac_b, exp_w);
   endtask

   task automatic t_scaled_b();
      int n = 0;
      full_b = 1'b0; empty_b = 1'b1;
      while (frst_b && n < 50) begin n++; cyc(); end
      full_b = 1'b1; cyc();
      chk("R6", "full in acquire restarts", frst_b, 1);
      chk("R12", "scaled restart count", rc_b, 1);
      acquire_b();
      frame_b(5'd11, 1006, "R8");
      frame_b(5'd7, 1004, "R8");
      frame_b(5'd4, 1000, "R9");
   endtask

   initial begin
      repeat (3) cyc();
      t_reset_state();
      rst_n = 1'b1;
      t_track_a();
      t_reacquire_a();
      fill_a = 5'd8; empty_a = 1'b0;
      t_scaled_b();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule